// File: doc/BRIEF.md
# Receiver Control Register Slave (I2C)

This block is the serial configuration port of a radio receiver. It watches the SCL and SDA pins of an I2C-compatible bus as a slave. It holds the bytes that set the synthesizer divide ratios, the reference and LO dividers, the gain cutbacks, the filter corner adjustments and the per-section shutdowns. Each register drives its fields straight to the analog sections through the output ports.

The slave answers at one of three 7-bit addresses, chosen by two strap pins. With both straps low it answers at none of them. A write carries a pointer byte after the address. Each data byte after the pointer lands in the slot the pointer names, and the pointer then steps by one. A read does not use the pointer. It always returns an all-zero byte first and then a byte that carries four live status flags. That status byte repeats for as long as the master keeps acknowledging.

The bus pins pass through two-flop synchronizers. The block runs on a system clock that is several times faster than SCL.

Top module: `rxc_i2c_ctl`

## Requirements
- R1: After reset the fields hold these values: slot 0 = 0x56, slot 1 = 0x1E, slot 2 = 0x90, slot 3 = 0x69, slot 4 = 0x60, slot 5 = 0x04, slot 6 = 0x00, slot 9 = 0x00. The SDA pull-down is inactive.
- R2: The 8-bit write/read address byte is 0xC2/0xC3 when the straps (sel1, sel2) are (0,1), 0xC4/0xC5 when they are (1,0), and 0xC6/0xC7 when they are (1,1). No address is acknowledged when both straps are 0, and no other address byte is ever acknowledged.
- R3: In a write, the byte after the address sets the pointer. Each later data byte is stored in the slot that the pointer names, and the pointer then increments. The slave acknowledges every byte: the address, the pointer and each data byte.
- R4: Data bytes sent to slots 7, 8 or 10 and above are acknowledged and discarded, with no change to any field. The pointer still steps past these slots.
- R5: A read returns 0x00 first, then a status byte {4'b0000, agc_engaged, ant_overcurrent, ant_detect, pll_locked} (bit 3 down to bit 0). The status byte repeats while the master acknowledges. Bytes are sent MSB first.
- R6: After the master NACKs a read byte, the slave releases SDA. It does not pull SDA low again until the next START.
- R7: A START seen at any point, including in the middle of a byte, discards the partial byte. The slave then takes the next 8 bits as a fresh address byte.
- R8: Slot 4 maps, from bit 7 down to bit 0, to: reference divide by two, high charge-pump current, LO divide by eight, RF-AGC power-down, antenna-supply power-down, front-end power-down, back-end power-down, PLL power-down.
- R9: The slave pulls SDA low only during its own acknowledge bit or while it is sending a 0 data bit. It never pulls SDA low when it has not been addressed.
- R10: After an address byte that is not acknowledged, the bytes that follow up to the next START are not acknowledged, and they change no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock pin level |
| sda_i | input | 1 | Bus data pin level |
| sda_drive_low_o | output | 1 | Enables the open-drain pull-down on SDA |
| sel1_i | input | 1 | Address strap, first select |
| sel2_i | input | 1 | Address strap, second select |
| agc_engaged_i | input | 1 | Status flag: RF AGC engaged |
| ant_overcurrent_i | input | 1 | Status flag: antenna supply overcurrent |
| ant_detect_i | input | 1 | Status flag: antenna load current detected |
| pll_locked_i | input | 1 | Status flag: PLL in lock |
| refout_half_o | output | 1 | Slot 0 bit 7: reference output divided by two |
| n_int_o | output | 7 | Slot 0 bits 6:0: integer divide ratio |
| pll_mode_o | output | 4 | Slot 1 bits 7:4: bit 0 enables fractional mode, bits 3:1 are auxiliary mode bits |
| n_frac_o | output | 20 | Fractional divide ratio: slot 1 bits 3:0 then slots 2 and 3 |
| ref_half_o | output | 1 | Slot 4 bit 7: reference divide by two |
| cp_high_o | output | 1 | Slot 4 bit 6: high charge-pump current |
| lo_div8_o | output | 1 | Slot 4 bit 5: second LO divides by eight |
| pd_agc_o | output | 1 | Slot 4 bit 4: RF-AGC power-down |
| pd_ant_o | output | 1 | Slot 4 bit 3: antenna-supply power-down |
| pd_fe_o | output | 1 | Slot 4 bit 2: front-end power-down |
| pd_be_o | output | 1 | Slot 4 bit 1: back-end power-down |
| pd_pll_o | output | 1 | Slot 4 bit 0: PLL power-down |
| agc_thresh_o | output | 5 | Slot 5 bits 7:3: RF-AGC engagement threshold code |
| lpf_shift_o | output | 2 | Slot 5 bits 2:1: low-pass corner nudge |
| bb_boost_o | output | 1 | Slot 5 bit 0: back-end gain boost |
| fe_cut_o | output | 4 | Slot 6 bits 7:4: front-end gain cutback |
| pd_refbuf_o | output | 1 | Slot 6 bit 3: reference buffer power-down |
| test_sel_o | output | 3 | Slot 6 bits 2:0: test mode select |
| lpf_trim_o | output | 8 | Slot 9: low-pass trim (bit 5 selects the manual code, bits 4:0 hold the code) |

## Verification
Each SCL or SDA edge reaches the protocol logic three clock edges after the pin moves: two synchronizer flops and one edge-compare flop. So the slave's acknowledge and data bits settle about three cycles after an SCL fall, and a stored byte reaches its field about three cycles after the fall that ends its eighth bit. The bench moves SDA eight cycles after each SCL fall and samples SDA eight cycles after each SCL rise, which stays clear of that latency on both sides. It reads the register fields only after the STOP of a transfer, or a full bit time after the last clocked byte, so every write has settled before it is compared.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

   localparam int SLOT_COUNT = 10;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } link_st_e;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_PTR,
      PH_DATA
   } phase_e;

   // Slots that hold storage; every other index reads as zero.
   function automatic logic slot_used(input int idx);
      return (idx >= 0 && idx <= 6) || (idx == 9);
   endfunction

   function automatic logic [7:0] slot_reset(input int idx);
      case (idx)
         0: return 8'h56;
         1: return 8'h1E;
         2: return 8'h90;
         3: return 8'h69;
         4: return 8'h60;
         5: return 8'h04;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/rxc_bus_sync.sv
module rxc_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rxc_bus_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_d, sda_d, scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_d    <= scl_pipe[STAGES-1];
         sda_d    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s    = scl_pipe[STAGES-1];
   assign sda_s    = sda_pipe[STAGES-1];
   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/rxc_link.sv
module rxc_link #(
   parameter logic [4:0] DEV_ID_HI = 5'b11000,
   parameter int         PTR_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_ev,
   input  logic             stop_ev,
   input  logic             sda_s,
   input  logic             sel1,
   input  logic             sel2,
   input  logic [7:0]       status_byte,
   output logic             sda_low,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_addr,
   output logic [7:0]       wr_data
);
   import rxc_pkg::*;

   link_st_e   st;
   phase_e     ph;
   logic [3:0] bitcnt;
   logic [7:0] shreg, txreg;
   logic [PTR_W-1:0] ptr;
   logic       rd_mode, nack;
   logic       addr_ok;

   assign addr_ok = (shreg[7:1] == {DEV_ID_HI, sel1, sel2}) && (sel1 || sel2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         ph      <= PH_ADDR;
         bitcnt  <= '0;
         shreg   <= '0;
         txreg   <= '0;
         ptr     <= '0;
         rd_mode <= 1'b0;
         nack    <= 1'b1;
         sda_low <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_ev) begin
            st      <= ST_RX;
            ph      <= PH_ADDR;
            bitcnt  <= '0;
            rd_mode <= 1'b0;
            sda_low <= 1'b0;
         end else if (stop_ev) begin
            st      <= ST_IDLE;
            sda_low <= 1'b0;
         end else begin
            case (st)
               ST_RX: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     bitcnt <= '0;
                     case (ph)
                        PH_ADDR: begin
                           if (addr_ok) begin
                              st      <= ST_ACK;
                              sda_low <= 1'b1;
                              rd_mode <= shreg[0];
                              ph      <= PH_PTR;
                           end else begin
                              st <= ST_IDLE;
                           end
                        end
                        PH_PTR: begin
                           ptr     <= shreg[PTR_W-1:0];
                           ph      <= PH_DATA;
                           st      <= ST_ACK;
                           sda_low <= 1'b1;
                        end
                        default: begin
                           wr_en   <= 1'b1;
                           wr_addr <= ptr;
                           wr_data <= shreg;
                           ptr     <= ptr + PTR_W'(1);
                           st      <= ST_ACK;
                           sda_low <= 1'b1;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (rd_mode) begin
                        txreg   <= 8'h00;
                        sda_low <= 1'b1;
                        st      <= ST_TX;
                     end else begin
                        sda_low <= 1'b0;
                        st      <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bitcnt == 4'd8) begin
                        sda_low <= 1'b0;
                        bitcnt  <= '0;
                        st      <= ST_MACK;
                     end else begin
                        txreg   <= {txreg[6:0], 1'b0};
                        sda_low <= ~txreg[6];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     nack <= sda_s;
                  end else if (scl_fall) begin
                     if (nack) begin
                        st <= ST_IDLE;
                     end else begin
                        txreg   <= status_byte;
                        sda_low <= ~status_byte[7];
                        st      <= ST_TX;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R9: an idle slave never holds the line
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_low);

   // R3: each stored byte advances the pointer by one
   assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (ptr == wr_addr + PTR_W'(1)));

   // R6: a STOP always returns to idle with the line released
   assert_stop_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev && !start_ev |=> (st == ST_IDLE) && !sda_low);

   // R7: a START restarts address reception from bit zero
   assert_start_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (st == ST_RX) && (ph == PH_ADDR) && (bitcnt == 4'd0));

   // R2: with both straps low no transfer gets past its address
   assert_no_strap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel1 && !sel2) |-> (ph == PH_ADDR) || (st == ST_IDLE) || (st == ST_RX && bitcnt == 4'd0 && ph == PH_ADDR));

endmodule

// File: rtl/rxc_regfile.sv
module rxc_regfile #(
   parameter int NUM_SLOTS = rxc_pkg::SLOT_COUNT,
   parameter int PTR_W     = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [PTR_W-1:0]       wr_addr,
   input  logic [7:0]             wr_data,
   output logic [NUM_SLOTS*8-1:0] regs_flat
);
   if (NUM_SLOTS < 10) begin : g_bad_slots
      $error("rxc_regfile: NUM_SLOTS must cover slot 9");
   end
   if ((1 << PTR_W) < NUM_SLOTS) begin : g_bad_ptr
      $error("rxc_regfile: PTR_W too narrow for NUM_SLOTS");
   end

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      if (rxc_pkg::slot_used(i)) begin : g_reg
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= rxc_pkg::slot_reset(i);
            else if (wr_en && wr_addr == PTR_W'(i))
               q <= wr_data;
         end
         assign regs_flat[i*8 +: 8] = q;
      end else begin : g_hole
         assign regs_flat[i*8 +: 8] = 8'h00;
      end
   end

   // R4: a write to a slot without storage leaves every field as it was
   assert_unused_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !rxc_pkg::slot_used(int'(wr_addr)) |=> $stable(regs_flat));

   // R3: a write to slot 0 shows the written byte on the next cycle
   assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (wr_addr == '0) |=> (regs_flat[7:0] == $past(wr_data)));

endmodule

// File: rtl/rxc_i2c_ctl.sv
module rxc_i2c_ctl #(
   parameter logic [4:0] DEV_ID_HI   = 5'b11000,
   parameter int         SYNC_STAGES = 2,
   parameter int         PTR_W       = 8,
   parameter int         NUM_SLOTS   = rxc_pkg::SLOT_COUNT
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_i,
   input  logic        sda_i,
   output logic        sda_drive_low_o,
   input  logic        sel1_i,
   input  logic        sel2_i,
   input  logic        agc_engaged_i,
   input  logic        ant_overcurrent_i,
   input  logic        ant_detect_i,
   input  logic        pll_locked_i,
   output logic        refout_half_o,
   output logic [6:0]  n_int_o,
   output logic [3:0]  pll_mode_o,
   output logic [19:0] n_frac_o,
   output logic        ref_half_o,
   output logic        cp_high_o,
   output logic        lo_div8_o,
   output logic        pd_agc_o,
   output logic        pd_ant_o,
   output logic        pd_fe_o,
   output logic        pd_be_o,
   output logic        pd_pll_o,
   output logic [4:0]  agc_thresh_o,
   output logic [1:0]  lpf_shift_o,
   output logic        bb_boost_o,
   output logic [3:0]  fe_cut_o,
   output logic        pd_refbuf_o,
   output logic [2:0]  test_sel_o,
   output logic [7:0]  lpf_trim_o
);
   localparam int S_INT  = 0 * 8;
   localparam int S_FR2  = 1 * 8;
   localparam int S_FR1  = 2 * 8;
   localparam int S_FR0  = 3 * 8;
   localparam int S_CTL  = 4 * 8;
   localparam int S_GAIN = 5 * 8;
   localparam int S_FE   = 6 * 8;
   localparam int S_TRIM = 9 * 8;

   if (PTR_W < 4) begin : g_bad_ptr
      $error("rxc_i2c_ctl: PTR_W must reach slot 9");
   end

   logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   logic wr_en;
   logic [PTR_W-1:0] wr_addr;
   logic [7:0] wr_data, status_byte;
   logic [NUM_SLOTS*8-1:0] regs_flat;

   assign status_byte = {4'b0000, agc_engaged_i, ant_overcurrent_i, ant_detect_i, pll_locked_i};

   rxc_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev)
   );

   rxc_link #(.DEV_ID_HI(DEV_ID_HI), .PTR_W(PTR_W)) link_i (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s),
      .sel1(sel1_i), .sel2(sel2_i), .status_byte(status_byte),
      .sda_low(sda_drive_low_o), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   rxc_regfile #(.NUM_SLOTS(NUM_SLOTS), .PTR_W(PTR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .regs_flat(regs_flat)
   );

   assign refout_half_o = regs_flat[S_INT+7];
   assign n_int_o       = regs_flat[S_INT +: 7];
   assign pll_mode_o    = regs_flat[S_FR2+4 +: 4];
   assign n_frac_o      = {regs_flat[S_FR2 +: 4], regs_flat[S_FR1 +: 8], regs_flat[S_FR0 +: 8]};
   assign {ref_half_o, cp_high_o, lo_div8_o, pd_agc_o,
           pd_ant_o, pd_fe_o, pd_be_o, pd_pll_o} = regs_flat[S_CTL +: 8];
   assign agc_thresh_o  = regs_flat[S_GAIN+3 +: 5];
   assign lpf_shift_o   = regs_flat[S_GAIN+1 +: 2];
   assign bb_boost_o    = regs_flat[S_GAIN];
   assign fe_cut_o      = regs_flat[S_FE+4 +: 4];
   assign pd_refbuf_o   = regs_flat[S_FE+3];
   assign test_sel_o    = regs_flat[S_FE +: 3];
   assign lpf_trim_o    = regs_flat[S_TRIM +: 8];

   if (NUM_SLOTS > 10) begin : g_extra
      logic unused_hi;
      assign unused_hi = ^regs_flat[NUM_SLOTS*8-1:80];
   end
   logic unused_holes;
   assign unused_holes = ^regs_flat[79:56];

   // R8: the power-down fields follow slot 4 bits 4..0 after a write there
   assert_ctl_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (wr_addr == PTR_W'(4)) |=> ({pd_agc_o, pd_ant_o, pd_fe_o, pd_be_o, pd_pll_o} == $past(wr_data[4:0])));

endmodule

// File: tb/rxc_i2c_ctl_tb_top.sv
module rxc_i2c_ctl_tb_top;
   localparam int Q = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda_m = 1'b1;
   logic sel1 = 1'b1, sel2 = 1'b1;
   logic agc = 1'b0, ovc = 1'b0, det = 1'b0, lock = 1'b0;
   logic sda_drive_low;
   wire  sda_line = sda_m & ~sda_drive_low;

   logic refout_half, ref_half, cp_high, lo_div8, pd_agc, pd_ant, pd_fe, pd_be, pd_pll;
   logic bb_boost, pd_refbuf;
   logic [6:0] n_int;
   logic [3:0] pll_mode, fe_cut;
   logic [19:0] n_frac;
   logic [4:0] agc_thresh;
   logic [1:0] lpf_shift;
   logic [2:0] test_sel;
   logic [7:0] lpf_trim;

   int vecs = 0, errs = 0;
   bit done = 1'b0;
   logic [7:0] model [10];

   always #2.5 clk = ~clk;

   rxc_i2c_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_drive_low_o(sda_drive_low), .sel1_i(sel1), .sel2_i(sel2),
      .agc_engaged_i(agc), .ant_overcurrent_i(ovc), .ant_detect_i(det), .pll_locked_i(lock),
      .refout_half_o(refout_half), .n_int_o(n_int), .pll_mode_o(pll_mode), .n_frac_o(n_frac),
      .ref_half_o(ref_half), .cp_high_o(cp_high), .lo_div8_o(lo_div8), .pd_agc_o(pd_agc),
      .pd_ant_o(pd_ant), .pd_fe_o(pd_fe), .pd_be_o(pd_be), .pd_pll_o(pd_pll),
      .agc_thresh_o(agc_thresh), .lpf_shift_o(lpf_shift), .bb_boost_o(bb_boost),
      .fe_cut_o(fe_cut), .pd_refbuf_o(pd_refbuf), .test_sel_o(test_sel), .lpf_trim_o(lpf_trim)
   );

   function automatic bit has_slot(input int p);
      return (p <= 6) || (p == 9);
   endfunction

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] slot_view(input int i);
      case (i)
         0: return {refout_half, n_int};
         1: return {pll_mode, n_frac[19:16]};
         2: return n_frac[15:8];
         3: return n_frac[7:0];
         4: return {ref_half, cp_high, lo_div8, pd_agc, pd_ant, pd_fe, pd_be, pd_pll};
         5: return {agc_thresh, lpf_shift, bb_boost};
         6: return {fe_cut, pd_refbuf, test_sel};
         default: return lpf_trim;
      endcase
   endfunction

   task automatic check_all(input string req);
      for (int i = 0; i < 10; i++)
         if (has_slot(i)) chk($sformatf("%s slot %0d", req, i), slot_view(i), model[i]);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wt(Q); scl = 1'b1; wt(2*Q); sda_m = 1'b0; wt(2*Q); scl = 1'b0; wt(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wt(Q); scl = 1'b1; wt(2*Q); sda_m = 1'b1; wt(2*Q);
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); b = sda_line; wt(Q); scl = 1'b0; wt(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic acked);
      logic a;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(a);
      acked = ~a;
   endtask

   task automatic recv_byte(input logic master_nack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
      put_bit(master_nack);
   endtask

   // full write: address, pointer, n data bytes; expect_ack picks the expected answers
   task automatic do_write(input string req, input logic [7:0] dev, input logic [7:0] ptr,
                           input logic [7:0] d [4], input int n, input logic expect_ack);
      logic a;
      logic [7:0] p;
      p = ptr;
      bus_start();
      send_byte(dev, a); chk({req, " address ack"}, a, expect_ack);
      send_byte(ptr, a); chk({req, " pointer ack"}, a, expect_ack);
      for (int k = 0; k < n; k++) begin
         send_byte(d[k], a); chk({req, " data ack"}, a, expect_ack);
         if (expect_ack && has_slot(int'(p))) model[p] = d[k];
         p = p + 8'd1;
      end
      bus_stop();
      wt(Q);
   endtask

   task automatic t_reset();
      model = '{8'h56, 8'h1E, 8'h90, 8'h69, 8'h60, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00};
      check_all("R1");
      chk("R1 sda released", sda_drive_low, 1'b0);
   endtask

   task automatic t_burst();
      sel1 = 1'b1; sel2 = 1'b1;
      do_write("R3 burst", 8'hC6, 8'h00, '{8'h12, 8'h9A, 8'h34, 8'h56}, 4, 1'b1);
      check_all("R3");
      do_write("R3 mid", 8'hC6, 8'h05, '{8'hFB, 8'hA7, 8'h00, 8'h00}, 2, 1'b1);
      check_all("R3 mid");
   endtask

   task automatic t_layout();
      sel1 = 1'b0; sel2 = 1'b1;
      do_write("R8", 8'hC2, 8'h04, '{8'hA5, 8'h00, 8'h00, 8'h00}, 1, 1'b1);
      chk("R8 ref", ref_half, 1'b1);   chk("R8 cp", cp_high, 1'b0);
      chk("R8 lo", lo_div8, 1'b1);     chk("R8 agc", pd_agc, 1'b0);
      chk("R8 ant", pd_ant, 1'b0);     chk("R8 fe", pd_fe, 1'b1);
      chk("R8 be", pd_be, 1'b0);       chk("R8 pll", pd_pll, 1'b1);
      do_write("R8", 8'hC2, 8'h04, '{8'h5A, 8'h00, 8'h00, 8'h00}, 1, 1'b1);
      chk("R8 cp2", cp_high, 1'b1);    chk("R8 agc2", pd_agc, 1'b1);
      chk("R8 pll2", pd_pll, 1'b0);
   endtask

   task automatic t_unused();
      sel1 = 1'b1; sel2 = 1'b1;
      do_write("R4 holes", 8'hC6, 8'h07, '{8'hFF, 8'hEE, 8'h2B, 8'h00}, 3, 1'b1);
      check_all("R4 holes");
      do_write("R4 high", 8'hC6, 8'h0A, '{8'h77, 8'h88, 8'h00, 8'h00}, 2, 1'b1);
      check_all("R4 high");
   endtask

   task automatic t_addr();
      logic a;
      sel1 = 1'b1; sel2 = 1'b0;
      bus_start(); send_byte(8'hC6, a); chk("R2 other strap", a, 1'b0); bus_stop();
      do_write("R2 C4", 8'hC4, 8'h05, '{8'hC3, 8'h00, 8'h00, 8'h00}, 1, 1'b1);
      sel1 = 1'b0; sel2 = 1'b0;
      bus_start(); send_byte(8'hC2, a); chk("R2 no strap C2", a, 1'b0); bus_stop();
      bus_start(); send_byte(8'hC6, a); chk("R2 no strap C6", a, 1'b0); bus_stop();
      sel1 = 1'b1; sel2 = 1'b1;
      bus_start(); send_byte(8'hC8, a); chk("R2 foreign", a, 1'b0); bus_stop();
      sel1 = 1'b0; sel2 = 1'b1;
      do_write("R10", 8'hC4, 8'h00, '{8'hFF, 8'h00, 8'h00, 8'h00}, 1, 1'b0);
      check_all("R10");
   endtask

   task automatic t_read();
      logic a, b;
      logic [7:0] v;
      bit pulled;
      sel1 = 1'b1; sel2 = 1'b1;
      agc = 1'b1; ovc = 1'b0; det = 1'b1; lock = 1'b0;
      bus_start(); send_byte(8'hC7, a); chk("R5 read ack", a, 1'b1);
      recv_byte(1'b0, v); chk("R5 reserved", v, 8'h00);
      recv_byte(1'b1, v); chk("R5 status", v, 8'h0A);
      pulled = 1'b0;
      for (int i = 0; i < 9; i++) begin get_bit(b); if (!b) pulled = 1'b1; end
      chk("R6 released after NACK", pulled, 1'b0);
      bus_stop();
      chk("R6 idle", sda_drive_low, 1'b0);
      sel1 = 1'b0; sel2 = 1'b1;
      agc = 1'b0; ovc = 1'b1; det = 1'b0; lock = 1'b1;
      bus_start(); send_byte(8'hC3, a); chk("R5 read ack C3", a, 1'b1);
      recv_byte(1'b0, v); chk("R5 reserved 2", v, 8'h00);
      recv_byte(1'b0, v); chk("R5 status 2", v, 8'h05);
      recv_byte(1'b1, v); chk("R5 status repeat", v, 8'h05);
      bus_stop();
      agc = 1'b1; wt(4*Q);
      chk("R9 no drive when idle", sda_drive_low, 1'b0);
      check_all("R5 fields intact");
   endtask

   task automatic t_restart();
      logic a;
      sel1 = 1'b1; sel2 = 1'b1;
      bus_start();
      put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
      do_write("R7 after partial address", 8'hC6, 8'h06, '{8'h3C, 8'h00, 8'h00, 8'h00}, 1, 1'b1);
      check_all("R7 a");
      bus_start();
      send_byte(8'hC6, a); send_byte(8'h00, a);
      put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
      do_write("R7 after partial data", 8'hC6, 8'h01, '{8'h4F, 8'h00, 8'h00, 8'h00}, 1, 1'b1);
      check_all("R7 b");
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         vecs++; errs++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      wt(5);
      rst_n = 1'b1;
      wt(4);
      t_reset();
      t_burst();
      t_layout();
      t_unused();
      t_addr();
      t_read();
      t_restart();
      done = 1'b1;
      finish_run();
   end

endmodule